// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address handed to a synchronous burst memory array. A burst opens when one of two active-low start strobes captures an external address: one driven by the processor side, one by the cache-controller side. The captured value becomes the first beat's address. A two-bit beat counter then sets the two least significant address bits on each later beat. The counter steps only on cycles where the active-low advance input is asserted and neither strobe is asserted. The bits above the lowest two stay fixed for the whole burst.

A static ordering select picks how the low bits walk through the four beats. When it is low, the sequence is linear: the captured low bits plus the beat count, modulo four. When it is high, the sequence is interleaved: the captured low bits XOR the beat count. All state changes on the rising clock edge. The output is built only from registered state and the ordering select.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with no strobe asserted, `addr_out` is all zeros.
- R2: If `ctrl_start_n` is low and `proc_start_n` is high at a rising edge, `addr_out` equals the sampled `addr_in` after that edge, whatever `chip_en` is.
- R3: If `proc_start_n` is low and `chip_en` is high at a rising edge, `addr_out` equals the sampled `addr_in` after that edge. This holds whatever `ctrl_start_n` is.
- R4: If `proc_start_n` is low and `chip_en` is low at an edge, nothing is loaded and nothing advances, even with `ctrl_start_n` or `adv_n` low. `addr_out` keeps its value.
- R5: With `order_sel` = 0, each edge with both strobes high and `adv_n` low adds 1, modulo 4, to `addr_out[1:0]`.
- R6: With `order_sel` = 1, beat k of a burst shows `addr_out[1:0]` = base[1:0] XOR k, for k = 0..3.
- R7: An edge with both strobes high and `adv_n` high leaves `addr_out` unchanged.
- R8: A fourth advance after a load brings the low bits back to the loaded low bits, in either order.
- R9: Between loads, `addr_out[ADDR_W-1:2]` never changes, including when linear stepping wraps from 3 to 0.
- R10: A strobe that loads during a burst restarts at beat 0 with the new address, even if `adv_n` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W | External address captured at burst start |
| proc_start_n | input | 1 | Processor-side start strobe, active low, gated by chip_en |
| ctrl_start_n | input | 1 | Controller-side start strobe, active low, ungated |
| adv_n | input | 1 | Advance to next beat, active low |
| chip_en | input | 1 | Chip enable that qualifies the processor strobe |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_out | output | ADDR_W | Address presented to the array |

## Verification
A corrupted beat counter shows on `addr_out[1:0]` at the next beat. The next beat means the next advance, or the next load, where the count should read zero. A base register that fails to hold shows on the upper bits at the first edge with no load. A gating fault in the processor strobe shows one edge later as a load, or as a missing one. Walking a full four-beat burst from a low base and from a high base, in both orders, exposes each of these within one to four cycles of the faulty edge.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              proc_start_n,
  input  logic              ctrl_start_n,
  input  logic              adv_n,
  input  logic              chip_en,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int BEAT_W = 2;

  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low_bits;

  wire proc_seen = !proc_start_n;
  wire load_now  = proc_seen ? chip_en : !ctrl_start_n;
  wire step_now  = !proc_seen && ctrl_start_n && !adv_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load_now) begin
      base_q <= addr_in;
      beat_q <= '0;
    end else if (step_now) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign low_bits = order_sel ? (base_q[BEAT_W-1:0] ^ beat_q)
                              : (base_q[BEAT_W-1:0] + beat_q);
  assign addr_out = {base_q[ADDR_W-1:BEAT_W], low_bits};
endmodule

module burst_addr_seq_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              proc_start_n,
  input logic              ctrl_start_n,
  input logic              adv_n,
  input logic              chip_en,
  input logic              order_sel,
  input logic [ADDR_W-1:0] addr_out
);
  p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_start_n && proc_start_n) |=> addr_out == $past(addr_in));

  p_proc_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_start_n && chip_en) |=> addr_out == $past(addr_in));

  p_gated_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_start_n && !chip_en) |=> (!$stable(order_sel) || $stable(addr_out)));

  p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_start_n && ctrl_start_n && !adv_n && !order_sel) |=>
      (order_sel || addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1)));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_start_n && ctrl_start_n && adv_n) |=> (!$stable(order_sel) || $stable(addr_out)));

  p_upper_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_start_n && ctrl_start_n) |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int W = 17;
  logic clk = 0, rst_n = 0;
  logic [W-1:0] addr_in = '0;
  logic proc_start_n = 1, ctrl_start_n = 1, adv_n = 1, chip_en = 0, order_sel = 0;
  logic [W-1:0] addr_out;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(W)) u_dut (.*);

  task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(logic p, logic c, logic a, logic en, logic [W-1:0] ad);
    @(negedge clk);
    proc_start_n = p; ctrl_start_n = c; adv_n = a; chip_en = en; addr_in = ad;
    @(posedge clk); #1;
  endtask

  function automatic logic [W-1:0] mk(logic [W-1:0] b, logic [1:0] lo);
    return {b[W-1:2], lo};
  endfunction

  task automatic t_reset();
    repeat (2) @(posedge clk); #1;
    chk("R1 in reset", addr_out, '0);
    @(negedge clk); rst_n = 1;
    cyc(1, 1, 1, 0, 17'h1ffff);
    chk("R1 after reset", addr_out, '0);
  endtask

  task automatic t_linear();
    logic [W-1:0] b = 17'h12346;
    order_sel = 0;
    cyc(1, 0, 0, 0, b);
    chk("R2 ctrl load", addr_out, b);
    for (int k = 1; k < 4; k++) begin
      cyc(1, 1, 0, 1, 17'h0);
      chk("R5 R9 linear beat", addr_out, mk(b, 2'(b[1:0] + k)));
    end
    cyc(1, 1, 0, 1, 17'h0);
    chk("R8 linear wrap", addr_out, b);
  endtask

  task automatic t_interleave();
    logic [W-1:0] b = 17'h0abc5;
    order_sel = 1;
    cyc(0, 1, 1, 1, b);
    chk("R3 proc load", addr_out, b);
    for (int k = 1; k < 4; k++) begin
      cyc(1, 1, 0, 0, 17'h0);
      chk("R6 interleaved beat", addr_out, mk(b, b[1:0] ^ 2'(k)));
    end
    cyc(1, 1, 0, 0, 17'h0);
    chk("R8 interleaved wrap", addr_out, b);
  endtask

  task automatic t_hold();
    logic [W-1:0] b = 17'h15553;
    order_sel = 0;
    cyc(0, 0, 0, 1, b);
    chk("R3 both strobes", addr_out, b);
    cyc(1, 1, 0, 1, 17'h0);
    chk("R9 carry kept out", addr_out, mk(b, 2'd0));
    cyc(1, 1, 1, 1, 17'h1ffff);
    cyc(1, 1, 1, 0, 17'h00000);
    chk("R7 idle hold", addr_out, mk(b, 2'd0));
  endtask

  task automatic t_block();
    logic [W-1:0] b = 17'h02220;
    order_sel = 0;
    cyc(1, 0, 1, 1, b);
    cyc(0, 0, 0, 0, 17'h1dddd);
    chk("R4 gated both strobes", addr_out, b);
    cyc(0, 1, 0, 0, 17'h1eeee);
    chk("R4 gated no advance", addr_out, b);
  endtask

  task automatic t_restart();
    logic [W-1:0] b = 17'h0f0f1;
    logic [W-1:0] n = 17'h13332;
    order_sel = 1;
    cyc(1, 0, 1, 0, b);
    cyc(1, 1, 0, 0, 17'h0);
    cyc(1, 1, 0, 0, 17'h0);
    chk("R6 mid burst", addr_out, mk(b, 2'b11));
    cyc(1, 0, 0, 0, n);
    chk("R10 restart beat0", addr_out, n);
    cyc(1, 1, 0, 0, 17'h0);
    chk("R10 R6 restart beat1", addr_out, mk(n, 2'b11));
  endtask

  initial begin
    t_reset();
    t_linear();
    t_interleave();
    t_hold();
    t_block();
    t_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule